// File: doc/BRIEF.md
# Warp Memory Coalescing Unit

This block takes one load request from a 32-lane warp and turns it into the smallest set of aligned 128-byte memory transactions. Each lane supplies a byte address for a 4-byte element, and an active-lane mask says which lanes take part. Every distinct 128-byte line touched by an active lane becomes exactly one outgoing transaction. A stride-1 access that starts on a line boundary therefore costs one transaction. A stride of 32 elements costs thirty-two.

A request is accepted with a valid/ready handshake and captured whole. Line addresses then leave one per cycle on a second valid/ready handshake. They come out in ascending order of the lowest lane that touches each line. When no line is left, a one-cycle `done` pulse marks the end of the request.

Three statistics stay on the outputs after `done` until the next request is accepted: useful bytes, transferred bytes and transaction count. Access efficiency is the useful count divided by the transferred count.

Top module: `warp_coalescer`

## Requirements
- R1: Every transaction address equals a lane address with its low 7 bits cleared (a multiple of 128).
- R2: One request yields exactly one transaction per distinct line touched by an active lane (mask bit i set means lane i is active). Inactive lanes add no line.
- R3: Transactions are issued in ascending order of the lowest-numbered active lane whose address falls in that line.
- R4: While a line is pending, `txn_valid` is high and `txn_line` is held stable until `txn_ready`. With `txn_ready` held high, one transaction is accepted every cycle with no gaps.
- R5: `req_ready` is high only when no request is in progress. Address or mask changes after acceptance have no effect on the request being served.
- R6: `done` is a single-cycle pulse in the cycle after the last transaction is accepted. With an all-zero mask, `done` comes in the cycle right after acceptance and no transaction is issued.
- R7: `stat_useful` equals 4 times the number of active lanes, whatever the address pattern.
- R8: `stat_count` equals the number of transactions issued, and `stat_xfer` equals 128 times `stat_count`. Both hold after `done` until the next acceptance.
- R9: After reset, `req_ready` is 1, `txn_valid` and `done` are 0, and all statistics are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32i+31:32i] |
| req_mask | input | 32 | Active lanes, bit i for lane i |
| txn_valid | output | 1 | Transaction line address offered |
| txn_ready | input | 1 | Memory side accepts the transaction |
| txn_line | output | 32 | 128-byte aligned line address |
| done | output | 1 | One-cycle end-of-request pulse |
| stat_useful | output | 8 | Useful bytes of the last request |
| stat_xfer | output | 13 | Transferred bytes of the last request |
| stat_count | output | 6 | Transactions of the last request |

## Verification
The bench targets several corner cases:
- **All lanes in one line, including all lanes on one address.** A unit that fails to merge lanes emits duplicate lines and inflates the count.
- **A line boundary crossed mid-warp, and lines laid out in descending order across lanes.** A unit that sorts by address or picks the highest lane breaks the required ordering.
- **An all-zero mask.** A wrong unit hangs or emits a spurious transaction.
- **Random back-pressure.** This exposes a line that changes or drops while stalled.
- **Addresses scrambled after acceptance.** This exposes a unit that reads the live inputs instead of its captured copy.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic {WC_IDLE = 1'b0, WC_BUSY = 1'b1} wc_state_t;

  // Clears the line-offset bits of a byte address.
  function automatic logic [63:0] wc_align(input logic [63:0] addr, input int off_bits);
    logic [63:0] m;
    m = {64{1'b1}} << off_bits;
    return addr & m;
  endfunction
endpackage

// File: rtl/wc_pick.sv
module wc_pick #(
  parameter int LANES = 32,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wc_match.sv
module wc_match #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic [LANES-1:0][ADDR_W-1:0] addr,
  input  logic [LANES-1:0]             pend,
  input  logic [ADDR_W-1:0]            target,
  output logic [LANES-1:0]             hit
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-OFF_W-1:0] tag;
    assign tag    = addr[g][ADDR_W-1:OFF_W];
    assign hit[g] = pend[g] && (tag == target[ADDR_W-1:OFF_W]);
  end
endmodule

// File: rtl/wc_stats.sv
module wc_stats #(
  parameter int LANES      = 32,
  parameter int ELEM_BYTES = 4,
  parameter int LINE_BYTES = 128,
  localparam int USE_W = $clog2(LANES * ELEM_BYTES + 1),
  localparam int XFR_W = $clog2(LANES * LINE_BYTES + 1),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LANES-1:0] mask,
  input  logic             fire,
  output logic [USE_W-1:0] useful,
  output logic [XFR_W-1:0] xfer,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] active_lanes(input logic [LANES-1:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < LANES; i++) n = n + CNT_W'(m[i]);
    return n;
  endfunction

  function automatic logic [XFR_W-1:0] bytes_moved(input logic [CNT_W-1:0] c);
    return XFR_W'(c) * XFR_W'(LINE_BYTES);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      useful <= '0;
      count  <= '0;
    end else if (start) begin
      useful <= USE_W'(active_lanes(mask)) * USE_W'(ELEM_BYTES);
      count  <= '0;
    end else if (fire) begin
      count  <= count + CNT_W'(1);
    end
  end

  assign xfer = bytes_moved(count);
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 4,
  parameter int LINE_BYTES = 128,
  localparam int IDX_W = $clog2(LANES),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int USE_W = $clog2(LANES * ELEM_BYTES + 1),
  localparam int XFR_W = $clog2(LANES * LINE_BYTES + 1),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_mask,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_line,
  output logic                    done,
  output logic [USE_W-1:0]        stat_useful,
  output logic [XFR_W-1:0]        stat_xfer,
  output logic [CNT_W-1:0]        stat_count
);
  import wc_pkg::*;

  wc_state_t                    state_q;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0]             pend_q;

  // Named internal events, also observed by the checker.
  logic             accept;
  logic             txn_fire;
  logic             pend_any;
  logic [IDX_W-1:0] lead_lane;
  logic [LANES-1:0] line_hit;
  logic [ADDR_W-1:0] lead_line;

  assign req_ready = (state_q == WC_IDLE);
  assign accept    = req_valid && req_ready;

  wc_pick #(.LANES(LANES)) u_pick (
    .pend (pend_q),
    .any  (pend_any),
    .idx  (lead_lane)
  );

  assign lead_line = ADDR_W'(wc_align(64'(addr_q[lead_lane]), OFF_W));

  wc_match #(.LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_match (
    .addr   (addr_q),
    .pend   (pend_q),
    .target (lead_line),
    .hit    (line_hit)
  );

  assign txn_valid = (state_q == WC_BUSY) && pend_any;
  assign txn_line  = lead_line;
  assign txn_fire  = txn_valid && txn_ready;
  assign done      = (state_q == WC_BUSY) && !pend_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WC_IDLE;
      addr_q  <= '0;
      pend_q  <= '0;
    end else begin
      case (state_q)
        WC_IDLE: if (accept) begin
          addr_q  <= req_addr;
          pend_q  <= req_mask;
          state_q <= WC_BUSY;
        end
        WC_BUSY: begin
          if (txn_fire) pend_q <= pend_q & ~line_hit;
          if (!pend_any) state_q <= WC_IDLE;
        end
        default: state_q <= WC_IDLE;
      endcase
    end
  end

  wc_stats #(.LANES(LANES), .ELEM_BYTES(ELEM_BYTES), .LINE_BYTES(LINE_BYTES)) u_stats (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .mask   (req_mask),
    .fire   (txn_fire),
    .useful (stat_useful),
    .xfer   (stat_xfer),
    .count  (stat_count)
  );
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 4,
  parameter int LINE_BYTES = 128,
  localparam int USE_W = $clog2(LANES * ELEM_BYTES + 1),
  localparam int XFR_W = $clog2(LANES * LINE_BYTES + 1),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_line,
  input logic              done,
  input logic [USE_W-1:0]  stat_useful,
  input logic [XFR_W-1:0]  stat_xfer,
  input logic [CNT_W-1:0]  stat_count,
  input logic              txn_fire,
  input logic              pend_any
);
  assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (int'(txn_line) % LINE_BYTES) == 0);

  assert_hold_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line)));

  assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!txn_valid && !pend_any));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(stat_count) * ELEM_BYTES <= int'(stat_useful)));

  assert_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(stat_xfer) == int'(stat_count) * LINE_BYTES));

  assert_stats_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !txn_fire && $past(req_ready)) |-> $stable(stat_count));
endmodule

bind warp_coalescer wc_checker #(
  .LANES(LANES), .ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES), .LINE_BYTES(LINE_BYTES)
) u_wc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .txn_valid   (txn_valid),
  .txn_ready   (txn_ready),
  .txn_line    (txn_line),
  .done        (done),
  .stat_useful (stat_useful),
  .stat_xfer   (stat_xfer),
  .stat_count  (stat_count),
  .txn_fire    (txn_fire),
  .pend_any    (pend_any)
);

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int AW = 32;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [NL*AW-1:0] req_addr = '0;
  logic [NL-1:0] req_mask = '0;
  logic          txn_valid;
  logic          txn_ready = 1'b0;
  logic [AW-1:0] txn_line;
  logic          done;
  logic [7:0]    stat_useful;
  logic [12:0]   stat_xfer;
  logic [5:0]    stat_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_coalescer u_warp_coalescer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_line(txn_line), .done(done),
    .stat_useful(stat_useful), .stat_xfer(stat_xfer), .stat_count(stat_count)
  );

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference model: walk lanes in ascending order, keep the first sighting of each line.
  task automatic run_req(input logic [NL*AW-1:0] a, input logic [NL-1:0] m,
                         input int rmode, input string name);
    logic [AW-1:0] exp_q[$];
    int n_exp, useful, cyc, seen_done;
    exp_q = {};
    useful = 0;
    for (int i = 0; i < NL; i++) begin
      if (m[i]) begin
        logic [AW-1:0] ln;
        bit found;
        ln = a[i*AW +: AW] & ~32'h7F;
        found = 0;
        foreach (exp_q[k]) if (exp_q[k] == ln) found = 1;
        if (!found) exp_q.push_back(ln);
        useful += 4;
      end
    end
    n_exp = exp_q.size();

    @(negedge clk);
    check(req_ready == 1'b1, {"R5 idle ready ", name}, req_ready, 1);
    req_valid = 1'b1;
    req_addr  = a;
    req_mask  = m;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;      // R5: changes after acceptance must be ignored
    req_mask  = ~m;
    seen_done = 0;
    for (cyc = 0; cyc < 400; cyc++) begin
      case (rmode)
        0: txn_ready = 1'b1;
        1: txn_ready = 1'($urandom_range(0, 1));
        default: txn_ready = cyc[0];
      endcase
      #1;
      check(req_ready == 1'b0, {"R5 busy ", name}, req_ready, 0);
      if (done) begin
        seen_done = 1;
        break;
      end
      if (exp_q.size() == 0) begin
        check(0, {"R2 extra transaction ", name}, txn_line, 0);
      end else begin
        check(txn_valid == 1'b1, {"R4 valid while pending ", name}, txn_valid, 1);
        check(txn_line == exp_q[0], {"R1 R3 line order ", name}, txn_line, exp_q[0]);
        if (txn_valid && txn_ready) void'(exp_q.pop_front());
      end
      @(negedge clk);
    end
    check(seen_done == 1, {"R6 done seen ", name}, seen_done, 1);
    check(exp_q.size() == 0, {"R2 lines left ", name}, exp_q.size(), 0);
    check(txn_valid == 1'b0, {"R6 no txn with done ", name}, txn_valid, 0);
    if (rmode == 0) check(cyc == n_exp, {"R4 R6 latency ", name}, cyc, n_exp);
    check(stat_count == n_exp, {"R8 count ", name}, stat_count, n_exp);
    check(stat_xfer == n_exp * 128, {"R8 xfer ", name}, stat_xfer, n_exp * 128);
    check(stat_useful == useful, {"R7 useful ", name}, stat_useful, useful);
    @(negedge clk);
    txn_ready = 1'b0;
    #1;
    check(done == 1'b0, {"R6 single pulse ", name}, done, 0);
    check(stat_count == n_exp, {"R8 hold ", name}, stat_count, n_exp);
    check(req_ready == 1'b1, {"R5 back idle ", name}, req_ready, 1);
  endtask

  initial begin
    logic [NL*AW-1:0] a;
    logic [NL-1:0]    m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check(req_ready == 1'b1, "R9 req_ready", req_ready, 1);
    check(txn_valid == 1'b0, "R9 txn_valid", txn_valid, 0);
    check(done == 1'b0, "R9 done", done, 0);
    check(stat_count == 0 && stat_xfer == 0 && stat_useful == 0, "R9 stats",
          {stat_count, stat_xfer, stat_useful}, 0);

    for (int i = 0; i < NL; i++) a[i*AW +: AW] = 32'h1000 + 4 * i;
    run_req(a, '1, 0, "stride1");                 // one line, full efficiency
    for (int i = 0; i < NL; i++) a[i*AW +: AW] = 32'h2000 + 128 * i;
    run_req(a, '1, 0, "stride32");                // 32 lines
    run_req(a, '0, 0, "zero mask");               // R6: no transaction
    for (int i = 0; i < NL; i++) a[i*AW +: AW] = 32'h3040 + 4 * i;
    run_req(a, '1, 2, "unaligned");               // crosses one boundary
    run_req(a, 32'h0000_FFFF, 0, "half mask");    // R2: inactive lanes add nothing
    for (int i = 0; i < NL; i++) a[i*AW +: AW] = 32'h4444;
    run_req(a, '1, 1, "same addr");
    for (int i = 0; i < NL; i++) a[i*AW +: AW] = 32'h8000 + 128 * ((NL - 1 - i) / 4) + 4 * (i % 4);
    run_req(a, '1, 0, "descending");              // R3: lane order, not address order
    for (int i = 0; i < NL; i++) a[i*AW +: AW] = 32'h5000 + 128 * (i % 3);
    run_req(a, 32'hAAAA_5555, 1, "interleave");
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < NL; i++) a[i*AW +: AW] = 32'h6000 + 4 * $urandom_range(0, 511);
      m = NL'($urandom);
      run_req(a, m, 1, "random");
    end
    summary();
  end
endmodule